// File: doc/BRIEF.md
# CAN Transmit Bit-Error Monitor

While a CAN node is transmitting, this block compares the bit the node drives onto the bus with the level it reads back at the sample point. A mismatch raises one of two sticky flags, depending on its direction. One flag is for a recessive bit read back as dominant. The other is for a dominant bit read back as recessive. Each flagged mismatch also produces a one-cycle pulse for the error-counter logic.

A recessive bit read back as dominant is legitimate in three phases: while the node competes in arbitration, in the acknowledge slot, and while it sends a passive error flag. Mismatches of that direction in those phases are ignored. Dominant-read-recessive mismatches have no such exemption. A status-read strobe clears both flags. Bit timing, bit stuffing and the counters themselves are outside this block.

Top module: `can_bit_err_mon`

## Requirements
- R1: A comparison takes place only in a cycle where both `sample_i` and `tx_active_i` are 1. In any other cycle, no flag is set and `err_pulse_o` is 0 in the following cycle.
- R2: With the default encoding (recessive = logic 1, dominant = logic 0 on `tx_bit_i` and `rx_bit_i`), a compared bit with `tx_bit_i`=1 and `rx_bit_i`=0 sets `rec_err_o` in the next cycle, unless an exemption applies.
- R3: While `in_arb_i` is 1, a recessive-sent/dominant-read mismatch sets no flag and gives no pulse.
- R4: While `in_ack_i` is 1, a recessive-sent/dominant-read mismatch sets no flag and gives no pulse.
- R5: While `pass_flag_i` is 1, a recessive-sent/dominant-read mismatch sets no flag and gives no pulse.
- R6: A compared bit with `tx_bit_i`=0 and `rx_bit_i`=1 sets `dom_err_o` in the next cycle, whatever the values of `in_arb_i`, `in_ack_i` and `pass_flag_i`.
- R7: `err_pulse_o` is 1 for exactly the cycle that follows each flagged mismatch, and is 0 otherwise.
- R8: `clear_i` clears both flags in the next cycle. A mismatch flagged in the same cycle as `clear_i` leaves its flag set.
- R9: A flag that is set stays set until `clear_i` is applied.
- R10: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Sample-point strobe |
| tx_active_i | input | 1 | Node is the transmitter |
| tx_bit_i | input | 1 | Bit driven onto the bus |
| rx_bit_i | input | 1 | Bit read back from the bus |
| in_arb_i | input | 1 | Arbitration field in progress |
| in_ack_i | input | 1 | Acknowledge slot in progress |
| pass_flag_i | input | 1 | Passive error flag being sent |
| clear_i | input | 1 | Status-read strobe that clears the flags |
| rec_err_o | output | 1 | Sticky flag: recessive sent, dominant read |
| dom_err_o | output | 1 | Sticky flag: dominant sent, recessive read |
| err_pulse_o | output | 1 | One-cycle pulse per flagged mismatch |

## Verification
The assertions make no assumption about how the phase indicators combine. Any mix of `in_arb_i`, `in_ack_i` and `pass_flag_i` is legal, including a mix that a real frame never produces. The clear assertion expects no sample strobe in the same cycle as the clear, so that no new set can compete with it. The bench clears the flags in a cycle with the strobe low. The bench also sweeps all 256 combinations of the seven monitor inputs and `clear_i`, so the cases where a set and a clear coincide are covered too.

// File: rtl/can_bem_pkg.sv
package can_bem_pkg;
  localparam int unsigned NUM_KINDS = 2;
  localparam int unsigned KIND_REC  = 0;  // recessive sent, dominant read
  localparam int unsigned KIND_DOM  = 1;  // dominant sent, recessive read
endpackage

// File: rtl/can_bem_classify.sv
module can_bem_classify
  import can_bem_pkg::*;
#(
  parameter logic RECESSIVE = 1'b1
) (
  input  logic                 sample_i,
  input  logic                 tx_active_i,
  input  logic                 tx_bit_i,
  input  logic                 rx_bit_i,
  input  logic                 in_arb_i,
  input  logic                 in_ack_i,
  input  logic                 pass_flag_i,
  output logic [NUM_KINDS-1:0] hit_o
);
  localparam logic DOMINANT = ~RECESSIVE;

  logic compare, sent_rec, read_dom, read_rec, exempt;

  always_comb begin
    compare  = sample_i & tx_active_i;
    sent_rec = (tx_bit_i == RECESSIVE);
    read_dom = (rx_bit_i == DOMINANT);
    read_rec = (rx_bit_i == RECESSIVE);
    // dominant overwrite of recessive is legal in these phases
    exempt   = in_arb_i | in_ack_i | pass_flag_i;
    hit_o           = '0;
    hit_o[KIND_REC] = compare & sent_rec & read_dom & ~exempt;
    hit_o[KIND_DOM] = compare & ~sent_rec & read_rec;
  end
endmodule

// File: rtl/can_bem_sticky.sv
module can_bem_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;  // set wins over clear
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/can_bit_err_mon.sv
module can_bit_err_mon
  import can_bem_pkg::*;
#(
  parameter logic RECESSIVE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  input  logic tx_active_i,
  input  logic tx_bit_i,
  input  logic rx_bit_i,
  input  logic in_arb_i,
  input  logic in_ack_i,
  input  logic pass_flag_i,
  input  logic clear_i,
  output logic rec_err_o,
  output logic dom_err_o,
  output logic err_pulse_o
);
  logic [NUM_KINDS-1:0] hit;
  logic [NUM_KINDS-1:0] flag_q;
  logic                 pulse_q;

  can_bem_classify #(.RECESSIVE(RECESSIVE)) u_classify (
    .sample_i    (sample_i),
    .tx_active_i (tx_active_i),
    .tx_bit_i    (tx_bit_i),
    .rx_bit_i    (rx_bit_i),
    .in_arb_i    (in_arb_i),
    .in_ack_i    (in_ack_i),
    .pass_flag_i (pass_flag_i),
    .hit_o       (hit)
  );

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_flag
    can_bem_sticky u_sticky (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (hit[k]),
      .clr_i  (clear_i),
      .q_o    (flag_q[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= |hit;
  end

  assign rec_err_o   = flag_q[KIND_REC];
  assign dom_err_o   = flag_q[KIND_DOM];
  assign err_pulse_o = pulse_q;
endmodule

// File: rtl/can_bit_err_mon_chk.sv
module can_bit_err_mon_chk #(
  parameter logic RECESSIVE = 1'b1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sample_i,
  input logic tx_active_i,
  input logic tx_bit_i,
  input logic rx_bit_i,
  input logic in_arb_i,
  input logic in_ack_i,
  input logic pass_flag_i,
  input logic clear_i,
  input logic rec_err_o,
  input logic dom_err_o,
  input logic err_pulse_o
);
  logic cmp, rec_mis, dom_mis, exempt;
  assign cmp     = sample_i && tx_active_i;
  assign rec_mis = cmp && tx_bit_i == RECESSIVE && rx_bit_i != RECESSIVE;
  assign dom_mis = cmp && tx_bit_i != RECESSIVE && rx_bit_i == RECESSIVE;
  assign exempt  = in_arb_i || in_ack_i || pass_flag_i;

  a_r1_no_compare: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp |=> !err_pulse_o);
  a_r2_rec_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_mis && !exempt |=> rec_err_o && err_pulse_o);
  a_r3_arb_exempt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_arb_i && !dom_mis |=> !err_pulse_o);
  a_r4_ack_exempt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ack_i && !dom_mis |=> !err_pulse_o);
  a_r5_pass_exempt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_flag_i && !dom_mis |=> !err_pulse_o);
  a_r6_dom_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dom_mis |=> dom_err_o && err_pulse_o);
  a_r7_pulse_has_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_o |-> rec_err_o || dom_err_o);
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i && !sample_i |=> !rec_err_o && !dom_err_o);
  a_r9_rec_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_err_o && !clear_i |=> rec_err_o);
  a_r9_dom_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dom_err_o && !clear_i |=> dom_err_o);
endmodule

bind can_bit_err_mon can_bit_err_mon_chk #(.RECESSIVE(RECESSIVE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sample_i    (sample_i),
  .tx_active_i (tx_active_i),
  .tx_bit_i    (tx_bit_i),
  .rx_bit_i    (rx_bit_i),
  .in_arb_i    (in_arb_i),
  .in_ack_i    (in_ack_i),
  .pass_flag_i (pass_flag_i),
  .clear_i     (clear_i),
  .rec_err_o   (rec_err_o),
  .dom_err_o   (dom_err_o),
  .err_pulse_o (err_pulse_o)
);

// File: tb/can_bit_err_mon_bench.sv
module can_bit_err_mon_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sample_i = 0, tx_active_i = 0, tx_bit_i = 1, rx_bit_i = 1;
  logic in_arb_i = 0, in_ack_i = 0, pass_flag_i = 0, clear_i = 0;
  logic rec_err_o, dom_err_o, err_pulse_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_bit_err_mon u_can_bit_err_mon (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample_i), .tx_active_i(tx_active_i),
    .tx_bit_i(tx_bit_i), .rx_bit_i(rx_bit_i), .in_arb_i(in_arb_i),
    .in_ack_i(in_ack_i), .pass_flag_i(pass_flag_i), .clear_i(clear_i),
    .rec_err_o(rec_err_o), .dom_err_o(dom_err_o), .err_pulse_o(err_pulse_o)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {rec,dom,pulse} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD/4);
    check("R10 in reset", {rec_err_o, dom_err_o, err_pulse_o}, 3'b000);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R10 after reset", {rec_err_o, dom_err_o, err_pulse_o}, 3'b000);

    for (int v = 0; v < 256; v++) begin
      logic s, a, t, r, ar, ak, pf, c, exp_rec, exp_dom;
      string tag;
      {c, pf, ak, ar, r, t, a, s} = v[7:0];
      exp_rec = s & a & t & ~r & ~ar & ~ak & ~pf;
      exp_dom = s & a & ~t & r;
      if (!(s && a))          tag = "R1 no compare";
      else if (!t && r)       tag = "R6 dom mismatch";
      else if (t && !r && ar) tag = "R3 arbitration";
      else if (t && !r && ak) tag = "R4 ack slot";
      else if (t && !r && pf) tag = "R5 passive flag";
      else if (t && !r)       tag = "R2 rec mismatch";
      else                    tag = "R1 match";
      if (c && (exp_rec || exp_dom)) tag = {tag, " / R8 set beats clear"};

      // clear cycle with no strobe
      sample_i = 0; clear_i = 1;
      @(negedge clk);
      check("R8 clear", {rec_err_o, dom_err_o, err_pulse_o}, 3'b000);

      // stimulus cycle
      sample_i = s; tx_active_i = a; tx_bit_i = t; rx_bit_i = r;
      in_arb_i = ar; in_ack_i = ak; pass_flag_i = pf; clear_i = c;
      @(negedge clk);
      check(tag, {rec_err_o, dom_err_o, 1'b0}, {exp_rec, exp_dom, 1'b0});
      check("R7 pulse", {2'b00, err_pulse_o}, {2'b00, exp_rec | exp_dom});

      // idle cycle: flags hold, pulse drops
      sample_i = 0; clear_i = 0;
      @(negedge clk);
      check("R9 sticky / R7 single pulse", {rec_err_o, dom_err_o, err_pulse_o},
            {exp_rec, exp_dom, 1'b0});
    end

    // both flags set, then a single clear
    sample_i = 1; tx_active_i = 1; tx_bit_i = 1; rx_bit_i = 0;
    in_arb_i = 0; in_ack_i = 0; pass_flag_i = 0; clear_i = 0;
    @(negedge clk);
    tx_bit_i = 0; rx_bit_i = 1;
    @(negedge clk);
    check("R7 back-to-back pulse", {rec_err_o, dom_err_o, err_pulse_o}, 3'b111);
    sample_i = 0;
    repeat (3) @(negedge clk);
    check("R9 both held", {rec_err_o, dom_err_o, err_pulse_o}, 3'b110);
    clear_i = 1;
    @(negedge clk);
    clear_i = 0;
    check("R8 both cleared", {rec_err_o, dom_err_o, err_pulse_o}, 3'b000);

    done = 1;
    summary();
    $finish;
  end
endmodule